// File: doc/BRIEF.md
# Flash Two-Cycle Command Decoder

This block is the command interpreter at the front of a NOR flash device. Each bus write presents an address and a 16-bit data word. The low byte of the data word is the opcode. The decoder recognises three two-cycle sequences:

- changes to the protection state of individual blocks;
- loading the read configuration register;
- programming a protection register.

It holds a two-bit protection state for each of a small number of blocks. It also holds the read configuration register and a pair of sticky sequence-error bits in an eight-bit status word.

A setup write of 0x60 opens a second cycle. In that second cycle, the opcode selects one of four actions: protecting the addressed block, unprotecting it, freezing it, or copying the low address bits into the read configuration register. Any other second cycle is consumed as a sequence error.

A setup write of 0xC0 makes the next write the protection-register program cycle. That cycle captures the address and data and runs a fixed-length busy period. While busy is high, the decoder accepts no command.

A one-bit read-mode output tells the surrounding read path what to return. When the output is 1, reads return array data. When it is 0, reads return status.

Top module: `flash_cmd_decoder`

## Requirements
- R1: While reset is asserted and one clock after its release:
  - every block's protection field reads 01;
  - `rcr_o` is 0x0000;
  - `sts_o` is 0x80;
  - `read_array_o` is 1;
  - `busy_o` is 0.
- R2: Block i's state sits at `lock_state_o[2*i+1:2*i]`, encoded 00 unprotected, 01 protected, 11 frozen. The block index is `wr_addr[BLK_LSB+2:BLK_LSB]` (address bits 18:16 by default) of the second write. After a 0x60 write:
  - a second write of 0x01 protects the addressed block;
  - a second write of 0xD0 unprotects it;
  - a second write of 0x2F freezes it.

  The new state is visible one clock after the second write.
- R3: A frozen block ignores 0xD0 and 0x01. Only reset returns it to 01.
- R4: After a 0x60 write, any second-write opcode other than 0x01, 0xD0, 0x2F or 0x03 has these effects:
  - it sets both `sts_o[5]` and `sts_o[4]`;
  - it leaves the block states and `rcr_o` unchanged.

  `sts_o[7]` is the inverse of `busy_o`. All other status bits are 0.
- R5: The error bits stay set until a 0x50 write arrives in the idle state, or until reset.
- R6: The read mode changes as follows:
  - 0x60 followed by 0x03 loads `rcr_o` with `wr_addr[15:0]` of the second write and sets `read_array_o` to 1;
  - a 0x60 or 0xC0 setup write clears `read_array_o`, and it stays 0 until a 0x03 completion.
- R7: A second write that causes a sequence error is consumed. The decoder returns to idle, and the error write is never taken as a new first write.
- R8: 0xC0 followed by any write has these effects:
  - `wr_addr` and `wr_data` of that write appear on `prot_addr_o` and `prot_data_o`;
  - `busy_o` is high for exactly BUSY_CYCLES clocks, starting one clock after the write.
- R9: While `busy_o` is high, every write is ignored.
- R10: Only `wr_data[7:0]` is decoded; the upper byte is ignored. In the idle state, writes of any byte other than 0x60, 0xC0 or 0x50 change nothing.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Bus write strobe, one cycle per write |
| wr_addr | input | ADDR_W | Write address |
| wr_data | input | 16 | Write data; low byte is the opcode |
| lock_state_o | output | 2*NUM_BLOCKS | Two-bit protection state per block |
| rcr_o | output | 16 | Read configuration register |
| sts_o | output | 8 | Status: bit 7 ready, bits 5 and 4 sequence error |
| read_array_o | output | 1 | 1 = reads return array data, 0 = status |
| busy_o | output | 1 | Protection-register program in progress |
| prot_addr_o | output | ADDR_W | Captured protection-register address |
| prot_data_o | output | 16 | Captured protection-register data |

## Verification
The assertions check the following on every cycle:
- the encoding of each protection field, and that a frozen field stays frozen;
- that the two error bits move together and fall only after an accepted 0x50;
- that `rcr_o` changes only together with array read mode;
- that a busy period never exceeds its length and no write during it changes the state.

Only the bench's scenarios can show the rest:
- the exact outcome of each of the 256 possible second-cycle opcodes after 0x60;
- that an erroneous cycle is consumed rather than re-decoded;
- that the upper data byte is ignored;
- the exact captured protection-register values.

// File: rtl/fcd_pkg.sv
// fcd_pkg: shared opcodes, lock-state encoding and sequencer types
// for the flash command decoder. Assumes opcodes occupy data bits 7:0.
package fcd_pkg;

    localparam logic [7:0] OP_SETUP_CFG  = 8'h60;
    localparam logic [7:0] OP_PROTECT    = 8'h01;
    localparam logic [7:0] OP_UNPROTECT  = 8'hD0;
    localparam logic [7:0] OP_FREEZE     = 8'h2F;
    localparam logic [7:0] OP_LOAD_RCR   = 8'h03;
    localparam logic [7:0] OP_SETUP_PROT = 8'hC0;
    localparam logic [7:0] OP_CLR_STS    = 8'h50;

    // Per-block protection state; 2'b10 is never produced.
    typedef enum logic [1:0] {
        LK_OPEN   = 2'b00,
        LK_PROT   = 2'b01,
        LK_FROZEN = 2'b11
    } lock_t;

    typedef enum logic [1:0] {
        LOP_NONE,
        LOP_PROTECT,
        LOP_UNPROTECT,
        LOP_FREEZE
    } lock_op_t;

    typedef enum logic [1:0] {
        SQ_IDLE,
        SQ_CFG_ARMED,
        SQ_PROT_ARMED
    } seq_state_t;

endpackage

// File: rtl/fcd_seq.sv
// fcd_seq: two-cycle command sequencer.
// Tracks whether a 0x60 or 0xC0 setup write is pending and turns the
// following write into a one-cycle action pulse. A write is accepted only
// when busy is low. A bad second cycle is consumed and raises err_set.
// Assumes wr_en is a single-cycle strobe per bus write.
module fcd_seq
    import fcd_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       wr_en,
    input  logic       busy,
    input  logic [7:0] opcode,
    output lock_op_t   lock_op,
    output logic       rcr_we,
    output logic       err_set,
    output logic       err_clr,
    output logic       prot_start,
    output logic       to_status,
    output logic       to_array
);

    seq_state_t state_q, state_d;
    logic       accept;

    assign accept = wr_en && !busy;

    // Decode the current write against the pending setup state.
    always_comb begin
        state_d    = state_q;
        lock_op    = LOP_NONE;
        rcr_we     = 1'b0;
        err_set    = 1'b0;
        err_clr    = 1'b0;
        prot_start = 1'b0;
        to_status  = 1'b0;
        to_array   = 1'b0;
        if (accept) begin
            case (state_q)
                SQ_IDLE: begin
                    case (opcode)
                        OP_SETUP_CFG: begin
                            state_d   = SQ_CFG_ARMED;
                            to_status = 1'b1;
                        end
                        OP_SETUP_PROT: begin
                            state_d   = SQ_PROT_ARMED;
                            to_status = 1'b1;
                        end
                        OP_CLR_STS: err_clr = 1'b1;
                        default: ;
                    endcase
                end
                SQ_CFG_ARMED: begin
                    state_d = SQ_IDLE;
                    case (opcode)
                        OP_PROTECT:   lock_op = LOP_PROTECT;
                        OP_UNPROTECT: lock_op = LOP_UNPROTECT;
                        OP_FREEZE:    lock_op = LOP_FREEZE;
                        OP_LOAD_RCR: begin
                            rcr_we   = 1'b1;
                            to_array = 1'b1;
                        end
                        default:      err_set = 1'b1;
                    endcase
                end
                SQ_PROT_ARMED: begin
                    state_d    = SQ_IDLE;
                    prot_start = 1'b1;
                end
                default: state_d = SQ_IDLE;
            endcase
        end
    end

    // Hold the sequencer state.
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= SQ_IDLE;
        else        state_q <= state_d;
    end

endmodule

// File: rtl/fcd_lock_bank.sv
// fcd_lock_bank: one two-bit protection state per block.
// Applies a single lock operation to the indexed block per cycle.
// A frozen block leaves that state only through reset.
// Assumes idx < NUM_BLOCKS.
module fcd_lock_bank
    import fcd_pkg::*;
#(
    parameter int NUM_BLOCKS = 8,
    parameter int BLK_W      = 3
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  lock_op_t                op,
    input  logic [BLK_W-1:0]        idx,
    output logic [2*NUM_BLOCKS-1:0] state_o
);

    for (genvar gi = 0; gi < NUM_BLOCKS; gi++) begin : g_blk
        lock_t cur_q;
        logic  hit;

        assign hit = (op != LOP_NONE) && (idx == BLK_W'(gi));

        // Update this block's state; frozen is absorbing.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                cur_q <= LK_PROT;
            end else if (hit && cur_q != LK_FROZEN) begin
                case (op)
                    LOP_PROTECT:   cur_q <= LK_PROT;
                    LOP_UNPROTECT: cur_q <= LK_OPEN;
                    LOP_FREEZE:    cur_q <= LK_FROZEN;
                    default:       cur_q <= cur_q;
                endcase
            end
        end

        assign state_o[2*gi +: 2] = cur_q;
    end

endmodule

// File: rtl/fcd_busy_timer.sv
// fcd_busy_timer: stand-in for the protection-register program algorithm.
// A start pulse loads BUSY_CYCLES, and busy stays high until the count
// reaches zero. Assumes BUSY_CYCLES >= 1 and no start while busy.
module fcd_busy_timer #(
    parameter int BUSY_CYCLES = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    output logic busy
);

    localparam int CNT_W = $clog2(BUSY_CYCLES + 1);

    logic [CNT_W-1:0] cnt_q;

    // Load on start, then count down to zero.
    always_ff @(posedge clk) begin
        if (!rst_n)            cnt_q <= '0;
        else if (start)        cnt_q <= CNT_W'(BUSY_CYCLES);
        else if (cnt_q != '0)  cnt_q <= cnt_q - 1'b1;
    end

    assign busy = (cnt_q != '0);

endmodule

// File: rtl/flash_cmd_decoder.sv
// flash_cmd_decoder: top of the two-cycle command interpreter.
// Wires the sequencer, lock bank and busy timer, and owns the status
// error pair, read configuration register, read mode and the captured
// protection-register write. Assumes ADDR_W >= BLK_LSB + block index
// width and ADDR_W >= 16.
module flash_cmd_decoder
    import fcd_pkg::*;
#(
    parameter int NUM_BLOCKS  = 8,
    parameter int ADDR_W      = 20,
    parameter int BLK_LSB     = 16,
    parameter int BUSY_CYCLES = 8
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    wr_en,
    input  logic [ADDR_W-1:0]       wr_addr,
    input  logic [15:0]             wr_data,
    output logic [2*NUM_BLOCKS-1:0] lock_state_o,
    output logic [15:0]             rcr_o,
    output logic [7:0]              sts_o,
    output logic                    read_array_o,
    output logic                    busy_o,
    output logic [ADDR_W-1:0]       prot_addr_o,
    output logic [15:0]             prot_data_o
);

    localparam int BLK_W = (NUM_BLOCKS > 1) ? $clog2(NUM_BLOCKS) : 1;

    lock_op_t         lock_op;
    logic             rcr_we, err_set, err_clr, prot_start;
    logic             to_status, to_array;
    logic             busy;
    logic             err_hi_q, err_lo_q;
    logic [15:0]      rcr_q;
    logic             rd_array_q;
    logic [ADDR_W-1:0] paddr_q;
    logic [15:0]      pdata_q;
    logic [BLK_W-1:0] blk_idx;

    assign blk_idx = wr_addr[BLK_LSB +: BLK_W];

    fcd_seq u_seq (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_en      (wr_en),
        .busy       (busy),
        .opcode     (wr_data[7:0]),
        .lock_op    (lock_op),
        .rcr_we     (rcr_we),
        .err_set    (err_set),
        .err_clr    (err_clr),
        .prot_start (prot_start),
        .to_status  (to_status),
        .to_array   (to_array)
    );

    fcd_lock_bank #(
        .NUM_BLOCKS (NUM_BLOCKS),
        .BLK_W      (BLK_W)
    ) u_bank (
        .clk     (clk),
        .rst_n   (rst_n),
        .op      (lock_op),
        .idx     (blk_idx),
        .state_o (lock_state_o)
    );

    fcd_busy_timer #(
        .BUSY_CYCLES (BUSY_CYCLES)
    ) u_timer (
        .clk   (clk),
        .rst_n (rst_n),
        .start (prot_start),
        .busy  (busy)
    );

    // Sticky sequence-error pair: set together, cleared by 0x50.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            err_hi_q <= 1'b0;
            err_lo_q <= 1'b0;
        end else if (err_set) begin
            err_hi_q <= 1'b1;
            err_lo_q <= 1'b1;
        end else if (err_clr) begin
            err_hi_q <= 1'b0;
            err_lo_q <= 1'b0;
        end
    end

    // Read configuration register load from the low address bits.
    always_ff @(posedge clk) begin
        if (!rst_n)      rcr_q <= 16'h0000;
        else if (rcr_we) rcr_q <= wr_addr[15:0];
    end

    // Read mode: status after any setup write, array after an RCR load.
    always_ff @(posedge clk) begin
        if (!rst_n)         rd_array_q <= 1'b1;
        else if (to_array)  rd_array_q <= 1'b1;
        else if (to_status) rd_array_q <= 1'b0;
    end

    // Capture the protection-register program write.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            paddr_q <= '0;
            pdata_q <= '0;
        end else if (prot_start) begin
            paddr_q <= wr_addr;
            pdata_q <= wr_data;
        end
    end

    assign sts_o        = {~busy, 1'b0, err_hi_q, err_lo_q, 4'b0000};
    assign rcr_o        = rcr_q;
    assign read_array_o = rd_array_q;
    assign busy_o       = busy;
    assign prot_addr_o  = paddr_q;
    assign prot_data_o  = pdata_q;

endmodule

// File: rtl/fcd_checker.sv
// fcd_checker: cycle-by-cycle properties of flash_cmd_decoder, bound to
// every instance of the top. Assumes reset is asserted at time zero.
module fcd_checker #(
    parameter int NUM_BLOCKS  = 8,
    parameter int BUSY_CYCLES = 8
) (
    input logic                    clk,
    input logic                    rst_n,
    input logic                    wr_en,
    input logic [15:0]             wr_data,
    input logic [2*NUM_BLOCKS-1:0] lock_state_o,
    input logic [15:0]             rcr_o,
    input logic [7:0]              sts_o,
    input logic                    read_array_o,
    input logic                    busy_o
);

    localparam int BC_W = $clog2(BUSY_CYCLES + 2) + 1;

    logic [BC_W-1:0] busy_run;

    // Length of the current busy run.
    always_ff @(posedge clk) begin
        if (!rst_n)      busy_run <= '0;
        else if (busy_o) busy_run <= busy_run + 1'b1;
        else             busy_run <= '0;
    end

    for (genvar gi = 0; gi < NUM_BLOCKS; gi++) begin : g_chk
        AST_LOCK_ENCODING: assert property (@(posedge clk) disable iff (!rst_n)
            lock_state_o[2*gi +: 2] != 2'b10); // R2
        AST_FROZEN_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
            ($past(rst_n) && $past(lock_state_o[2*gi +: 2]) == 2'b11)
            |-> lock_state_o[2*gi +: 2] == 2'b11); // R3
    end

    AST_ERR_PAIRED: assert property (@(posedge clk) disable iff (!rst_n)
        sts_o[5] == sts_o[4]); // R4

    AST_READY_BIT: assert property (@(posedge clk) disable iff (!rst_n)
        sts_o[7] == !busy_o); // R4

    AST_ERR_CLEAR_ONLY_BY_CMD: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $fell(sts_o[5]))
        |-> $past(wr_en && !busy_o && wr_data[7:0] == 8'h50)); // R5

    AST_RCR_WITH_ARRAY_MODE: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && !$stable(rcr_o)) |-> read_array_o); // R6

    AST_BUSY_RUN_LEN: assert property (@(posedge clk) disable iff (!rst_n)
        busy_run <= BC_W'(BUSY_CYCLES)); // R8

    AST_BUSY_FULL_LEN: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $fell(busy_o)) |-> busy_run == BC_W'(BUSY_CYCLES)); // R8

    AST_BUSY_IGNORES_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_o && wr_en)
        |=> ($stable(lock_state_o) && $stable(rcr_o) && $stable(sts_o[5:4]))); // R9

endmodule

bind flash_cmd_decoder fcd_checker #(
    .NUM_BLOCKS  (NUM_BLOCKS),
    .BUSY_CYCLES (BUSY_CYCLES)
) u_fcd_checker (
    .clk          (clk),
    .rst_n        (rst_n),
    .wr_en        (wr_en),
    .wr_data      (wr_data),
    .lock_state_o (lock_state_o),
    .rcr_o        (rcr_o),
    .sts_o        (sts_o),
    .read_array_o (read_array_o),
    .busy_o       (busy_o)
);

// File: tb/tb_flash_cmd_decoder.sv
// Self-checking bench: sweeps every block and every second-cycle opcode
// against a small arithmetic model of the requirements.
module tb_flash_cmd_decoder;

    localparam int NB = 8;
    localparam int AW = 20;
    localparam int BC = 8;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          wr_en = 1'b0;
    logic [AW-1:0] wr_addr = '0;
    logic [15:0]   wr_data = '0;
    logic [2*NB-1:0] lock_state_o;
    logic [15:0]   rcr_o;
    logic [7:0]    sts_o;
    logic          read_array_o, busy_o;
    logic [AW-1:0] prot_addr_o;
    logic [15:0]   prot_data_o;

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 1'b0;

    logic [1:0]  exp_lk [NB];
    logic [15:0] exp_rcr;
    logic        exp_err;
    logic        exp_ra;

    always #10 clk = ~clk;

    flash_cmd_decoder #(
        .NUM_BLOCKS(NB), .ADDR_W(AW), .BLK_LSB(16), .BUSY_CYCLES(BC)
    ) dut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .lock_state_o(lock_state_o), .rcr_o(rcr_o),
        .sts_o(sts_o), .read_array_o(read_array_o), .busy_o(busy_o),
        .prot_addr_o(prot_addr_o), .prot_data_o(prot_data_o)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    function automatic logic [2*NB-1:0] exp_vec();
        logic [2*NB-1:0] v;
        for (int i = 0; i < NB; i++) v[2*i +: 2] = exp_lk[i];
        return v;
    endfunction

    function automatic logic [1:0] nxt(input logic [1:0] cur, input logic [7:0] op);
        if (cur == 2'b11) return 2'b11;
        case (op)
            8'h01:   return 2'b01;
            8'hD0:   return 2'b00;
            8'h2F:   return 2'b11;
            default: return cur;
        endcase
    endfunction

    function automatic logic [AW-1:0] baddr(input int b, input logic [15:0] lo);
        return {1'b0, 3'(b), lo};
    endfunction

    // One bus write; called and returns at a falling edge.
    task automatic wr(input logic [AW-1:0] a, input logic [15:0] d);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic check_all(input string tag);
        chk({tag, " locks"}, 32'(lock_state_o), 32'(exp_vec()));
        chk({tag, " rcr"}, 32'(rcr_o), 32'(exp_rcr));
        chk({tag, " sts"}, 32'(sts_o), 32'({~busy_o, 1'b0, exp_err, exp_err, 4'b0}));
        chk({tag, " mode"}, 32'(read_array_o), 32'(exp_ra));
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        for (int i = 0; i < NB; i++) exp_lk[i] = 2'b01;
        exp_rcr = 16'h0; exp_err = 1'b0; exp_ra = 1'b1;
    endtask

    task automatic lock_cmd(input int b, input logic [7:0] op);
        wr(baddr(0, 16'h1234), 16'h0060);
        wr(baddr(b, 16'h0), {8'h00, op});
        exp_lk[b] = nxt(exp_lk[b], op);
        exp_ra = 1'b0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        @(negedge clk);
        do_reset();
        // R1: reset state
        check_all("R1 reset");
        chk("R1 busy", 32'(busy_o), 32'h0);
        chk("R1 sts", 32'(sts_o), 32'h80);

        // R10: idle writes of non-setup opcodes and the upper byte
        wr(baddr(0, 16'h0), 16'hFF01);
        wr(baddr(0, 16'h0), 16'h00D0);
        wr(baddr(0, 16'h0), 16'h002F);
        wr(baddr(0, 16'hBEEF), 16'h0003);
        wr(baddr(0, 16'h0), 16'h00FF);
        check_all("R10 idle ignore");
        wr(baddr(0, 16'h0), 16'hAB60);
        wr(baddr(2, 16'h0), 16'h12D0);
        exp_lk[2] = 2'b00; exp_ra = 1'b0;
        check_all("R10 upper byte");

        // R2/R6: every block through unprotect, protect, unprotect
        for (int b = 0; b < NB; b++) begin
            lock_cmd(b, 8'hD0); check_all("R2 unprotect");
            lock_cmd(b, 8'h01); check_all("R2 protect");
            lock_cmd(b, 8'hD0); check_all("R2 unprotect2 R6 mode");
        end

        // R7: error cycle is consumed, not reused as a setup
        wr(baddr(0, 16'h0), 16'h0060);
        wr(baddr(3, 16'h0), 16'h0060);
        wr(baddr(3, 16'h0), 16'h0001);
        exp_err = 1'b1; exp_ra = 1'b0;
        check_all("R7 consumed R4 err");
        // R5: sticky until 0x50
        wr(baddr(5, 16'h0), 16'h0077);
        check_all("R5 sticky");
        wr(baddr(0, 16'h0), 16'h0050);
        exp_err = 1'b0;
        check_all("R5 cleared");

        // R4/R6: exhaustive second-cycle opcode sweep
        for (int v = 0; v < 256; v++) begin
            logic [15:0] lo;
            lo = 16'(v * 257) ^ 16'h5A5A;
            wr(baddr(0, 16'h0), 16'h0060);
            exp_ra = 1'b0;
            wr(baddr(v % NB, lo), {8'h00, 8'(v)});
            case (8'(v))
                8'h01, 8'hD0, 8'h2F: exp_lk[v % NB] = nxt(exp_lk[v % NB], 8'(v));
                8'h03: begin exp_rcr = lo; exp_ra = 1'b1; end
                default: exp_err = 1'b1;
            endcase
            check_all("R4 sweep");
            if (exp_err) begin
                wr(baddr(0, 16'h0), 16'h0050);
                exp_err = 1'b0;
                check_all("R5 sweep clear");
            end
        end

        // R3: frozen blocks ignore unprotect and protect
        lock_cmd(1, 8'h2F); check_all("R3 freeze");
        lock_cmd(1, 8'hD0); check_all("R3 unprotect ignored");
        lock_cmd(1, 8'h01); check_all("R3 protect ignored");
        chk("R3 frozen field", 32'(lock_state_o[3:2]), 32'h3);
        do_reset();
        check_all("R1 R3 reset clears frozen");

        // R8: protection-register program capture and busy length
        wr(baddr(0, 16'h0), 16'h00C0);
        exp_ra = 1'b0;
        chk("R6 C0 mode", 32'(read_array_o), 32'h0);
        wr(20'hA5C3C, 16'h9E17);
        chk("R8 paddr", 32'(prot_addr_o), 32'hA5C3C);
        chk("R8 pdata", 32'(prot_data_o), 32'h9E17);
        chk("R8 sts busy", 32'(sts_o), 32'h00);
        begin
            int n;
            n = 0;
            while (busy_o && n < 100) begin n++; @(negedge clk); end
            chk("R8 busy length", 32'(n), 32'(BC));
        end
        chk("R8 sts ready", 32'(sts_o), 32'h80);

        // R9: writes during busy are ignored
        lock_cmd(4, 8'hD0); check_all("R9 prep");
        wr(baddr(0, 16'h0), 16'h00C0);
        wr(20'h01111, 16'h2222);
        wr(baddr(0, 16'h0), 16'h0060);
        wr(baddr(4, 16'h0), 16'h002F);
        wr(baddr(0, 16'h0), 16'h00C0);
        wr(20'h03333, 16'h4444);
        while (busy_o) @(negedge clk);
        wr(baddr(4, 16'h0), 16'h0001);
        check_all("R9 busy ignore");
        chk("R9 paddr kept", 32'(prot_addr_o), 32'h01111);
        chk("R9 pdata kept", 32'(prot_data_o), 32'h2222);

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule